// File: doc/BRIEF.md
# Key-Locked Routine Loader

The block copies one of several built-in routines from a hidden storage memory into on-chip RAM when software asks for it. Software unlocks it by writing the unlock value 0xA5 to a key register, picks exactly one routine in a select register (bit 0 is the programming routine, higher bits are erase routines), sets a RAM destination address, and then writes the start bit. The start write is accepted only when the key is unlocked, RAM emulation is off, and the write comes from code that is fetched out of on-chip RAM. Otherwise the write is dropped.

Once a start is accepted, the block checks the selection and the destination. It maps the storage area into the user space while it copies. It streams the routine into RAM one 32-bit word per clock, and it writes a result byte at the destination. It then hands the memory map back, clears the select bits and the start bit, and lets go of any interrupts it held back during the download. The destination's first word is reserved for the result. The routine image lands in the words that follow it.

The RAM write port is a valid/ready stream. Once `ram_wr_valid` is high it stays high, and address, data and strobes stay unchanged, until a cycle in which `ram_wr_ready` is also high. The block never drops a word under back-pressure. It stops issuing storage reads whenever a word is already waiting. The storage read port has a fixed latency of one cycle.

Top module: `rtn_loader`

## Requirements
- R1: A start write takes effect only while the key register holds 0xA5. A write to the key register of 0xA5 unlocks it. A write of any other value clears it to 0x00, and a start written while the key is not 0xA5 leaves `busy` low.
- R2: A start write (address 3, data bit 0 set) is dropped when `emu_mode` is high or when `fetch_in_ram` is low during the write cycle.
- R3: The selection is valid only when exactly one select bit is set. Otherwise no storage read and no routine word write occur, and only the result byte is written, with bit 0 of the result set.
- R4: The destination is invalid when it is not a multiple of 4, lies below RAM_BASE, or leaves too little room for 4*(COPY_WORDS+1) bytes below RAM_BASE+RAM_BYTES. Result bit 1 flags this, no copy occurs, and both error bits may be set together.
- R5: For a valid request selecting bit s, word i (0 to COPY_WORDS-1) is read from storage address s*COPY_WORDS+i. It is written in increasing order of i to RAM address dest+4+4*i, with all four byte strobes set.
- R6: After the last routine word, or at once for a rejected request, the block writes the result byte to address dest with strobe 4'b0001 and the code in data bits [7:0]. The code is 0x00 for success.
- R7: While `ram_wr_valid` is high and `ram_wr_ready` is low, the address, data and strobes hold. With `ram_wr_ready` held high, the routine words and the result byte are written on consecutive cycles.
- R8: `map_storage` is high only while routine words are being read, and it is low for a rejected request.
- R9: `busy` rises in the cycle after the accepted start write and falls in the cycle after the result write is accepted. Register writes while `busy` is high are ignored. On completion, the select register and the start bit (register 3 bit 0, which reads as `busy`) read 0.
- R10: When idle, `irq_out` follows `irq_in`. While `busy` is high, `irq_out` is 0 and incoming requests are collected. The collected requests are shown on `irq_out` in the first cycle after `busy` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_we | input | 1 | Register write strobe |
| csr_addr | input | 2 | Register index: 0 key, 1 select, 2 destination, 3 control |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Read data for the register at `csr_addr` |
| emu_mode | input | 1 | RAM emulation active |
| fetch_in_ram | input | 1 | The current write comes from code fetched out of on-chip RAM |
| rom_rd_en | output | 1 | Storage read request |
| rom_rd_addr | output | SAW | Storage word address |
| rom_rd_data | input | 32 | Storage data, valid one cycle after the request |
| ram_wr_valid | output | 1 | RAM write valid |
| ram_wr_ready | input | 1 | RAM accepts the write |
| ram_wr_addr | output | AW | RAM byte address |
| ram_wr_data | output | 32 | RAM write data |
| ram_wr_strb | output | 4 | Byte strobes |
| map_storage | output | 1 | Storage area mapped in place of the user space |
| busy | output | 1 | Download in progress |
| irq_in | input | IRQ_N | Incoming interrupt requests |
| irq_out | output | IRQ_N | Requests passed to the interrupt controller |

## Verification
The hardest case to reach from the ports is a stalled write that meets a storage read already in flight. The returned word has to go into the holding register without overwriting the word that is waiting. To get there, the bench drives `ram_wr_ready` from a shift-register pattern during an erase-routine download and checks every word and address it logs. A second hard case is an interrupt that arrives in the middle of a download. It is injected a cycle after the start is accepted, and the bench looks for it on the first idle cycle.

// File: rtl/rl_pkg.sv
package rl_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_COPY, ST_RESULT} rl_state_e;
  localparam logic [1:0] REG_KEY  = 2'd0;
  localparam logic [1:0] REG_SEL  = 2'd1;
  localparam logic [1:0] REG_DEST = 2'd2;
  localparam logic [1:0] REG_CTRL = 2'd3;
  localparam logic [7:0] UNLOCK_KEY = 8'hA5;
  localparam int ERR_SEL_BIT  = 0;
  localparam int ERR_DEST_BIT = 1;
endpackage

// File: rtl/rl_regs.sv
module rl_regs
  import rl_pkg::*;
#(
  parameter int          AW         = 32,
  parameter logic [31:0] RAM_BASE   = 32'h0010_0000,
  parameter int          RAM_BYTES  = 4096,
  parameter int          COPY_WORDS = 8,
  parameter int          SELW       = 3,
  parameter int          IDXW       = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            csr_we,
  input  logic [1:0]      csr_addr,
  input  logic [31:0]     csr_wdata,
  output logic [31:0]     csr_rdata,
  input  logic            emu_mode,
  input  logic            fetch_in_ram,
  input  logic            busy,
  input  logic            done,
  output logic            go,
  output logic [7:0]      go_code,
  output logic [IDXW-1:0] go_idx,
  output logic [AW-1:0]   dest_q,
  output logic [7:0]      key_q
);
  localparam logic [AW-1:0] DEST_LO = AW'(RAM_BASE);
  localparam logic [AW-1:0] DEST_HI =
    AW'(RAM_BASE + 32'(RAM_BYTES) - 32'(4 * (COPY_WORDS + 1)));

  logic [SELW-1:0] sel_q;
  logic            wr_ok;
  logic            sel_bad, dest_bad;

  assign wr_ok = csr_we && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q  <= '0;
      sel_q  <= '0;
      dest_q <= '0;
    end else begin
      if (done) sel_q <= '0;
      if (wr_ok) begin
        case (csr_addr)
          REG_KEY:  key_q  <= (csr_wdata[7:0] == UNLOCK_KEY) ? UNLOCK_KEY : 8'h00;
          REG_SEL:  sel_q  <= csr_wdata[SELW-1:0];
          REG_DEST: dest_q <= csr_wdata[AW-1:0];
          default:  ;
        endcase
      end
    end
  end

  assign go = wr_ok && (csr_addr == REG_CTRL) && csr_wdata[0] &&
              (key_q == UNLOCK_KEY) && !emu_mode && fetch_in_ram;

  always_comb begin
    go_idx = '0;
    for (int i = 0; i < SELW; i++)
      if (sel_q[i]) go_idx = IDXW'(i);
  end

  assign sel_bad  = ($countones(sel_q) != 1);
  assign dest_bad = (dest_q[1:0] != 2'b00) || (dest_q < DEST_LO) || (dest_q > DEST_HI);

  always_comb begin
    go_code = '0;
    go_code[ERR_SEL_BIT]  = sel_bad;
    go_code[ERR_DEST_BIT] = dest_bad;
  end

  always_comb begin
    case (csr_addr)
      REG_KEY:  csr_rdata = {24'h0, key_q};
      REG_SEL:  csr_rdata = 32'(sel_q);
      REG_DEST: csr_rdata = 32'(dest_q);
      default:  csr_rdata = {31'h0, busy};
    endcase
  end
endmodule

// File: rtl/rl_copy.sv
module rl_copy
  import rl_pkg::*;
#(
  parameter int AW         = 32,
  parameter int COPY_WORDS = 8,
  parameter int IDXW       = 2,
  parameter int SAW        = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            go,
  input  logic [7:0]      go_code,
  input  logic [IDXW-1:0] go_idx,
  input  logic [AW-1:0]   dest,
  output logic            rom_rd_en,
  output logic [SAW-1:0]  rom_rd_addr,
  input  logic [31:0]     rom_rd_data,
  output logic            ram_wr_valid,
  input  logic            ram_wr_ready,
  output logic [AW-1:0]   ram_wr_addr,
  output logic [31:0]     ram_wr_data,
  output logic [3:0]      ram_wr_strb,
  output logic            map_storage,
  output logic            busy,
  output logic            done
);
  localparam int CW = $clog2(COPY_WORDS + 1);

  rl_state_e      state;
  logic [CW-1:0]  rd_cnt, wr_cnt;
  logic [SAW-1:0] base_q;
  logic [7:0]     code_q;
  logic           inflight, wbuf_v;
  logic [31:0]    wbuf;
  logic           fire, issue, copy_v;

  assign copy_v = wbuf_v || inflight;
  assign fire   = ram_wr_valid && ram_wr_ready;
  assign issue  = (state == ST_COPY) && (rd_cnt < CW'(COPY_WORDS)) && (!copy_v || fire);

  assign rom_rd_en   = issue;
  assign rom_rd_addr = base_q + SAW'(rd_cnt);
  assign map_storage = (state == ST_COPY);
  assign busy        = (state != ST_IDLE);
  assign done        = (state == ST_RESULT) && fire;

  always_comb begin
    ram_wr_valid = 1'b0;
    ram_wr_addr  = dest;
    ram_wr_data  = {24'h0, code_q};
    ram_wr_strb  = 4'b0001;
    if (state == ST_COPY) begin
      ram_wr_valid = copy_v;
      ram_wr_addr  = dest + AW'(4) + AW'({wr_cnt, 2'b00});
      ram_wr_data  = wbuf_v ? wbuf : rom_rd_data;
      ram_wr_strb  = 4'b1111;
    end else if (state == ST_RESULT) begin
      ram_wr_valid = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      rd_cnt   <= '0;
      wr_cnt   <= '0;
      base_q   <= '0;
      code_q   <= '0;
      inflight <= 1'b0;
      wbuf_v   <= 1'b0;
      wbuf     <= '0;
    end else begin
      case (state)
        ST_IDLE: if (go) begin
          code_q <= go_code;
          base_q <= SAW'(go_idx) * SAW'(COPY_WORDS);
          rd_cnt <= '0;
          wr_cnt <= '0;
          state  <= (go_code != 8'h00) ? ST_RESULT : ST_COPY;
        end
        ST_COPY: begin
          inflight <= issue;
          if (issue) rd_cnt <= rd_cnt + 1'b1;
          wbuf_v <= copy_v && !fire;
          if (inflight && !wbuf_v) wbuf <= rom_rd_data;
          if (fire) begin
            wr_cnt <= wr_cnt + 1'b1;
            if (wr_cnt == CW'(COPY_WORDS - 1)) state <= ST_RESULT;
          end
        end
        ST_RESULT: if (fire) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rl_irq_hold.sv
module rl_irq_hold #(
  parameter int IRQ_N = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             busy,
  input  logic [IRQ_N-1:0] irq_in,
  output logic [IRQ_N-1:0] irq_out
);
  logic [IRQ_N-1:0] pend_q;

  assign irq_out = busy ? '0 : (irq_in | pend_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else if (busy) pend_q <= pend_q | irq_in;
    else pend_q <= '0;
  end
endmodule

// File: rtl/rtn_loader.sv
module rtn_loader
  import rl_pkg::*;
#(
  parameter int          AW         = 32,
  parameter logic [31:0] RAM_BASE   = 32'h0010_0000,
  parameter int          RAM_BYTES  = 4096,
  parameter int          COPY_WORDS = 8,
  parameter int          NUM_ERASE  = 2,
  parameter int          IRQ_N      = 4,
  parameter int          SELW       = NUM_ERASE + 1,
  parameter int          IDXW       = (SELW > 1) ? $clog2(SELW) : 1,
  parameter int          SAW        = $clog2(SELW * COPY_WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             csr_we,
  input  logic [1:0]       csr_addr,
  input  logic [31:0]      csr_wdata,
  output logic [31:0]      csr_rdata,
  input  logic             emu_mode,
  input  logic             fetch_in_ram,
  output logic             rom_rd_en,
  output logic [SAW-1:0]   rom_rd_addr,
  input  logic [31:0]      rom_rd_data,
  output logic             ram_wr_valid,
  input  logic             ram_wr_ready,
  output logic [AW-1:0]    ram_wr_addr,
  output logic [31:0]      ram_wr_data,
  output logic [3:0]       ram_wr_strb,
  output logic             map_storage,
  output logic             busy,
  input  logic [IRQ_N-1:0] irq_in,
  output logic [IRQ_N-1:0] irq_out
);
  logic            go, done;
  logic [7:0]      go_code, key_q;
  logic [IDXW-1:0] go_idx;
  logic [AW-1:0]   dest_q;

  rl_regs #(
    .AW(AW), .RAM_BASE(RAM_BASE), .RAM_BYTES(RAM_BYTES),
    .COPY_WORDS(COPY_WORDS), .SELW(SELW), .IDXW(IDXW)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .emu_mode(emu_mode),
    .fetch_in_ram(fetch_in_ram), .busy(busy), .done(done), .go(go),
    .go_code(go_code), .go_idx(go_idx), .dest_q(dest_q), .key_q(key_q)
  );

  rl_copy #(
    .AW(AW), .COPY_WORDS(COPY_WORDS), .IDXW(IDXW), .SAW(SAW)
  ) u_copy (
    .clk(clk), .rst_n(rst_n), .go(go), .go_code(go_code), .go_idx(go_idx),
    .dest(dest_q), .rom_rd_en(rom_rd_en), .rom_rd_addr(rom_rd_addr),
    .rom_rd_data(rom_rd_data), .ram_wr_valid(ram_wr_valid),
    .ram_wr_ready(ram_wr_ready), .ram_wr_addr(ram_wr_addr),
    .ram_wr_data(ram_wr_data), .ram_wr_strb(ram_wr_strb),
    .map_storage(map_storage), .busy(busy), .done(done)
  );

  rl_irq_hold #(.IRQ_N(IRQ_N)) u_irq (
    .clk(clk), .rst_n(rst_n), .busy(busy), .irq_in(irq_in), .irq_out(irq_out)
  );
endmodule

// File: rtl/rtn_loader_chk.sv
module rtn_loader_chk #(
  parameter int AW    = 32,
  parameter int IRQ_N = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             csr_we,
  input logic [1:0]       csr_addr,
  input logic [31:0]      csr_wdata,
  input logic             emu_mode,
  input logic             fetch_in_ram,
  input logic             busy,
  input logic             map_storage,
  input logic             rom_rd_en,
  input logic             ram_wr_valid,
  input logic             ram_wr_ready,
  input logic [AW-1:0]    ram_wr_addr,
  input logic [31:0]      ram_wr_data,
  input logic [3:0]       ram_wr_strb,
  input logic [IRQ_N-1:0] irq_out,
  input logic [7:0]       key_q
);
  p_start_key_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(key_q == 8'hA5));

  p_start_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(csr_we && csr_addr == 2'd3 && csr_wdata[0] &&
                          !emu_mode && fetch_in_ram));

  p_read_in_map_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rom_rd_en |-> map_storage);

  p_result_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_wr_valid && !map_storage) |-> (ram_wr_strb == 4'b0001));

  p_hold_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_wr_valid && !ram_wr_ready) |=> (ram_wr_valid && $stable(ram_wr_addr) &&
                                          $stable(ram_wr_data) && $stable(ram_wr_strb)));

  p_map_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    map_storage |-> busy);

  p_write_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ram_wr_valid |-> busy);

  p_irq_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (irq_out == '0));
endmodule

bind rtn_loader rtn_loader_chk #(.AW(AW), .IRQ_N(IRQ_N)) u_chk (
  .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_addr(csr_addr),
  .csr_wdata(csr_wdata), .emu_mode(emu_mode), .fetch_in_ram(fetch_in_ram),
  .busy(busy), .map_storage(map_storage), .rom_rd_en(rom_rd_en),
  .ram_wr_valid(ram_wr_valid), .ram_wr_ready(ram_wr_ready),
  .ram_wr_addr(ram_wr_addr), .ram_wr_data(ram_wr_data),
  .ram_wr_strb(ram_wr_strb), .irq_out(irq_out), .key_q(key_q)
);

// File: tb/test_rtn_loader.sv
`timescale 1ns/1ps
module test_rtn_loader;
  localparam int          AW = 32;
  localparam logic [31:0] RB = 32'h0010_0000;
  localparam int          RBYTES = 4096;
  localparam int          CWORDS = 8;
  localparam int          IRQN = 4;
  localparam int          SAW = 5;

  logic clk = 0, rst_n = 0;
  logic csr_we = 0;
  logic [1:0] csr_addr = 0;
  logic [31:0] csr_wdata = 0, csr_rdata;
  logic emu_mode = 0, fetch_in_ram = 1;
  logic rom_rd_en;
  logic [SAW-1:0] rom_rd_addr;
  logic [31:0] rom_rd_data = 0;
  logic ram_wr_valid, ram_wr_ready = 1;
  logic [AW-1:0] ram_wr_addr;
  logic [31:0] ram_wr_data;
  logic [3:0] ram_wr_strb;
  logic map_storage, busy;
  logic [IRQN-1:0] irq_in = 0, irq_out;

  int n_chk = 0, n_bad = 0;
  int cyc = 0, log_n = 0, rd_n = 0, map_n = 0, irq_leak = 0;
  logic [31:0] lg_addr [64];
  logic [31:0] lg_data [64];
  logic [3:0]  lg_strb [64];
  int          lg_cyc  [64];
  bit rdy_all = 1;
  logic [7:0] lfsr = 8'h5B;

  rtn_loader #(.RAM_BASE(RB), .RAM_BYTES(RBYTES), .COPY_WORDS(CWORDS),
               .NUM_ERASE(2), .IRQ_N(IRQN)) i_rtn_loader (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .emu_mode(emu_mode),
    .fetch_in_ram(fetch_in_ram), .rom_rd_en(rom_rd_en), .rom_rd_addr(rom_rd_addr),
    .rom_rd_data(rom_rd_data), .ram_wr_valid(ram_wr_valid),
    .ram_wr_ready(ram_wr_ready), .ram_wr_addr(ram_wr_addr),
    .ram_wr_data(ram_wr_data), .ram_wr_strb(ram_wr_strb),
    .map_storage(map_storage), .busy(busy), .irq_in(irq_in), .irq_out(irq_out));

  always #10 clk = ~clk;

  function automatic logic [31:0] rom_fn(input int a);
    return 32'h5100_00F3 ^ (32'(a) * 32'h0001_0101);
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (rom_rd_en) begin rom_rd_data <= rom_fn(int'(rom_rd_addr)); rd_n++; end
    if (map_storage) map_n++;
    if (busy && irq_out != 0) irq_leak++;
    if (ram_wr_valid && ram_wr_ready && log_n < 64) begin
      lg_addr[log_n] = ram_wr_addr; lg_data[log_n] = ram_wr_data;
      lg_strb[log_n] = ram_wr_strb; lg_cyc[log_n] = cyc; log_n++;
    end
  end

  always @(negedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    ram_wr_ready <= rdy_all ? 1'b1 : lfsr[0];
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic csr_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); csr_we = 1; csr_addr = a; csr_wdata = d;
    @(negedge clk); csr_we = 0;
  endtask

  task automatic csr_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); csr_addr = a; #1 d = csr_rdata;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 2000 && busy; i++) @(negedge clk);
  endtask

  task automatic launch(input logic [2:0] sel, input logic [31:0] dest);
    log_n = 0; rd_n = 0; map_n = 0;
    csr_write(2'd0, 32'hA5);
    csr_write(2'd1, 32'(sel));
    csr_write(2'd2, dest);
    csr_write(2'd3, 32'h1);
  endtask

  task automatic do_dl(input logic [2:0] sel, input logic [31:0] dest,
                       input logic [7:0] exp_code, input string tag);
    int idx, errs, gaps;
    logic [31:0] v;
    idx = (sel == 3'b001) ? 0 : (sel == 3'b010) ? 1 : 2;
    launch(sel, dest);
    check(busy === 1'b1, {tag, " R9 busy after start"}, 32'(busy), 1);
    wait_idle();
    if (exp_code == 0) begin
      check(log_n == CWORDS + 1, {tag, " R5 write count"}, log_n, CWORDS + 1);
      errs = 0;
      for (int i = 0; i < CWORDS; i++)
        if (lg_addr[i] !== dest + 4 + 4 * i || lg_data[i] !== rom_fn(idx * CWORDS + i) ||
            lg_strb[i] !== 4'hF) errs++;
      check(errs == 0, {tag, " R5 word content"}, errs, 0);
      check(rd_n == CWORDS, {tag, " R5 storage reads"}, rd_n, CWORDS);
      check(map_n >= CWORDS, {tag, " R8 map during copy"}, map_n, CWORDS);
      if (rdy_all) begin
        gaps = 0;
        for (int i = 1; i <= CWORDS; i++) if (lg_cyc[i] != lg_cyc[i-1] + 1) gaps++;
        check(gaps == 0, {tag, " R7 one word per cycle"}, gaps, 0);
      end
    end else begin
      check(log_n == 1, {tag, " R3 only result written"}, log_n, 1);
      check(rd_n == 0, {tag, " R3 no storage read"}, rd_n, 0);
      check(map_n == 0, {tag, " R8 no map on reject"}, map_n, 0);
    end
    if (log_n > 0) begin
      check(lg_addr[log_n-1] === dest && lg_strb[log_n-1] === 4'b0001,
            {tag, " R6 result address/strobe"}, lg_addr[log_n-1], dest);
      check(lg_data[log_n-1][7:0] === exp_code, {tag, " R6 result code"},
            32'(lg_data[log_n-1][7:0]), 32'(exp_code));
    end
    check(map_storage === 1'b0, {tag, " R8 map released"}, 32'(map_storage), 0);
    csr_read(2'd1, v); check(v == 0, {tag, " R9 select cleared"}, v, 0);
    csr_read(2'd3, v); check(v == 0, {tag, " R9 start cleared"}, v, 0);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check(!busy && !map_storage && !rom_rd_en && !ram_wr_valid && irq_out == 0,
          "R9 reset outputs", {busy, map_storage, rom_rd_en, ram_wr_valid}, 0);
    csr_read(2'd0, v); check(v == 0, "R1 reset key", v, 0);
  endtask

  task automatic t_key();
    logic [31:0] v;
    log_n = 0;
    csr_write(2'd1, 32'h1); csr_write(2'd2, RB);
    csr_write(2'd0, 32'h5A);
    csr_read(2'd0, v); check(v == 0, "R1 wrong key reads 0", v, 0);
    csr_write(2'd3, 32'h1);
    repeat (3) @(negedge clk);
    check(!busy && log_n == 0, "R1 locked start ignored", 32'(busy), 0);
    csr_write(2'd0, 32'hA5);
    csr_read(2'd0, v); check(v == 32'hA5, "R1 key unlocks", v, 32'hA5);
    csr_write(2'd0, 32'h12);
    csr_read(2'd0, v); check(v == 0, "R1 other value relocks", v, 0);
    csr_write(2'd3, 32'h1);
    repeat (3) @(negedge clk);
    check(!busy, "R1 relocked start ignored", 32'(busy), 0);
  endtask

  task automatic t_gate();
    log_n = 0;
    csr_write(2'd0, 32'hA5);
    emu_mode = 1; csr_write(2'd3, 32'h1); emu_mode = 0;
    repeat (2) @(negedge clk);
    check(!busy, "R2 emulation blocks start", 32'(busy), 0);
    fetch_in_ram = 0; csr_write(2'd3, 32'h1); fetch_in_ram = 1;
    repeat (2) @(negedge clk);
    check(!busy && log_n == 0, "R2 fetch outside RAM blocks start", 32'(busy), 0);
  endtask

  task automatic t_busy_write();
    logic [31:0] v;
    launch(3'b001, RB + 32'h40);
    csr_write(2'd2, RB + 32'h80);
    csr_write(2'd1, 32'h4);
    wait_idle();
    csr_read(2'd2, v); check(v == RB + 32'h40, "R9 dest write during busy ignored", v, RB + 32'h40);
    csr_read(2'd1, v); check(v == 0, "R9 select write during busy ignored", v, 0);
  endtask

  task automatic t_irq();
    @(negedge clk); irq_in = 4'b0010; #1;
    check(irq_out == 4'b0010, "R10 idle pass-through", 32'(irq_out), 2);
    irq_in = 0;
    irq_leak = 0;
    launch(3'b010, RB + 32'h200);
    irq_in = 4'b0101; @(negedge clk); irq_in = 0;
    wait_idle(); #1;
    check(irq_out == 4'b0101, "R10 held request released", 32'(irq_out), 5);
    @(negedge clk); #1;
    check(irq_out == 0, "R10 released once", 32'(irq_out), 0);
    check(irq_leak == 0, "R10 masked while busy", irq_leak, 0);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_key();
    t_gate();
    do_dl(3'b001, RB + 32'h100, 8'h00, "prog");
    rdy_all = 0;
    do_dl(3'b100, RB + 32'h300, 8'h00, "erase backpressure");
    rdy_all = 1;
    do_dl(3'b011, RB + 32'h100, 8'h01, "two selects R3");
    do_dl(3'b000, RB + 32'h100, 8'h01, "no select R3");
    do_dl(3'b001, RB + 32'h102, 8'h02, "misaligned R4");
    do_dl(3'b110, RB - 32'h10, 8'h03, "below range R4");
    do_dl(3'b001, RB + RBYTES - 4 * (CWORDS + 1), 8'h00, "top edge R4");
    do_dl(3'b001, RB + RBYTES - 4 * CWORDS, 8'h02, "past top R4");
    t_busy_write();
    t_irq();
    summary();
    $finish;
  end
endmodule